// File: doc/BRIEF.md
# Link BIST Pattern Checker

This block is the receive-side self-test checker of a serial link. Each clock it takes one parallel payload word from the link receiver, along with a lock flag. While a test run is active it compares every payload bit against a locally regenerated reference. The transmitter sends an all-zeros stream that has been scrambled, so the reference is the scrambler sequence itself. A single result output reports the outcome. While the run is active it shows a short low pulse for every bad word. Once the run ends it holds a pass or fail verdict.

A run is started and stopped either by an external enable pin or by a control register bit, and a register bit picks which one. The clock-source choice for the far end is forwarded when a run starts. A separate test output can be held quiet, made to alternate, or made to follow the received data. A small register port gives access to the control fields and to a count of errored words.

Top module: `link_bist_checker`

## Requirements
- R1: After reset, pass_o is 0, test_out_o is 0, rem_clk_src_o is 0, the control register (address 0) reads 0x08 and the error counter (address 1) reads 0.
- R2: When control bit 3 (pin select) is 1, the run enable and the clock source come from bist_en_pin_i and clk_src_pin_i. When bit 3 is 0, they come from control bit 0 (enable) and bits 2:1 (clock source), and the pins have no effect.
- R3: When a run starts, the error counter clears and pass_o is 0 until the first clock edge at which rx_lock_i is 1. That word is not checked: it seeds the reference. pass_o is 1 from that edge on.
- R4: The reference follows s[n] = s[n-31] XOR s[n-28]. Word k carries s[35k+i] on bit i, and the seed word is k=0. Matching words keep pass_o at 1 through both clock phases.
- R5: A checked word with any bit differing from the reference drives pass_o low during the high phase of the clock after the edge that sampled it. pass_o returns to 1 in the low phase.
- R6: After seeding, each cycle with rx_lock_i at 0 counts as an errored word and pulses pass_o like R5. The reference still advances by one word.
- R7: When the selected enable falls, checking stops at that edge. From then on pass_o holds 1 if the run was seeded and saw no errored word, and 0 otherwise. It stays fixed until the next run starts, whatever rx_lock_i and rx_word_i do.
- R8: The error counter at address 1 adds one per errored word, saturates at all ones, keeps its value after the run stops, and reads 0 once a new run starts.
- R9: rem_clk_src_o captures the selected clock-source code at the start of a run and holds it for the whole run. Code 00 means external pixel clock; 01, 10 and 11 mean internal pixel clock and are passed through unchanged.
- R10: test_out_o depends on control bits 7:6 during a seeded run. With 00 it stays 0. With 01 it starts at 0 on the seeding edge and inverts at each later edge. With 1x it takes bit 0 of the word sampled at each later edge. Outside a seeded run it is 0.
- R11: Writes to address 0 store bits 7:6 and 3:0. Bits 5:4 read as 0, and the register keeps its value when no write is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_word_i | input | 35 | Payload word from the link receiver |
| rx_lock_i | input | 1 | Receiver lock flag |
| bist_en_pin_i | input | 1 | Run enable pin |
| clk_src_pin_i | input | 2 | Clock-source select pins |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| pass_o | output | 1 | Live error pulses during a run, verdict afterwards |
| rem_clk_src_o | output | 2 | Clock-source code forwarded to the far end |
| test_out_o | output | 1 | Test output selected by the output mode |

## Verification
A reference register that is out of step with the stream shows up one edge after seeding. Every following word then pulses pass_o low and the counter rises each cycle, so clean runs expose it at once. A run flag or error flag stuck in the wrong state is seen at the stop edge, where the verdict on pass_o no longer matches the count of injected faults. Errors and lock drops are injected at the first checked word, in the middle of a run, in the same cycle and at the last word, so that a pulse or a count that is off by one cycle cannot go unseen.

// File: rtl/link_bist_pkg.sv
`timescale 1ns/1ps
package link_bist_pkg;
  typedef struct packed {
    logic [1:0] out_mode;
    logic       pin_cfg;
    logic [1:0] clk_src;
    logic       en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{out_mode: 2'b00, pin_cfg: 1'b1, clk_src: 2'b00, en: 1'b0};
  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_ERRCNT = 1;
  localparam logic [1:0]  OUT_QUIET   = 2'b00;
  localparam logic [1:0]  OUT_ALT     = 2'b01;
endpackage

// File: rtl/link_bist_ref_gen.sv
`timescale 1ns/1ps
module link_bist_ref_gen #(
  parameter int unsigned WORD_W = 35,
  parameter int unsigned LFSR_W = 31,
  parameter int unsigned TAP    = 28
) (
  input  logic [LFSR_W-1:0] hist_i,
  output logic [WORD_W-1:0] exp_o,
  output logic [LFSR_W-1:0] next_o
);
  localparam int unsigned EXT_W = LFSR_W + WORD_W;
  localparam int unsigned DIST  = LFSR_W - TAP;

  logic [EXT_W-1:0] ext;

  // ext[j] = s[n-LFSR_W+j]; unrolled WORD_W steps of the recurrence
  always_comb begin
    ext = '0;
    ext[LFSR_W-1:0] = hist_i;
    for (int j = 0; j < WORD_W; j++) begin
      ext[j+LFSR_W] = ext[j] ^ ext[j+DIST];
    end
  end

  assign exp_o  = ext[EXT_W-1:LFSR_W];
  assign next_o = ext[EXT_W-1:WORD_W];
endmodule

// File: rtl/link_bist_regs.sv
`timescale 1ns/1ps
module link_bist_regs
  import link_bist_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned RD_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [CNT_W-1:0]  err_cnt_i,
  output ctrl_t             ctrl_o,
  output logic [RD_W-1:0]   rdata_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_i && addr_i == ADDR_W'(ADDR_CTRL)) begin
      ctrl_q <= '{out_mode: wdata_i[7:6], pin_cfg: wdata_i[3],
                  clk_src: wdata_i[2:1], en: wdata_i[0]};
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(ADDR_CTRL):   rdata_o = RD_W'({ctrl_q.out_mode, 2'b00, ctrl_q.pin_cfg,
                                             ctrl_q.clk_src, ctrl_q.en});
      ADDR_W'(ADDR_ERRCNT): rdata_o = RD_W'(err_cnt_i);
      default:              rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;

  a_r11_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_q));
endmodule

// File: rtl/link_bist_checker.sv
`timescale 1ns/1ps
module link_bist_checker
  import link_bist_pkg::*;
#(
  parameter int unsigned WORD_W = 35,
  parameter int unsigned LFSR_W = 31,
  parameter int unsigned TAP    = 28,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              rx_lock_i,
  input  logic              bist_en_pin_i,
  input  logic [1:0]        clk_src_pin_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              pass_o,
  output logic [1:0]        rem_clk_src_o,
  output logic              test_out_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ctrl_t             ctrl;
  logic              run_en;
  logic [1:0]        src_sel;
  logic              run_q, synced_q, err_seen_q, pulse_q, verdict_q, tog_q;
  logic [CNT_W-1:0]  err_cnt_q;
  logic [LFSR_W-1:0] hist_q, hist_nxt;
  logic [WORD_W-1:0] exp_word;
  logic [1:0]        src_q;
  logic              word_err;

  link_bist_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RD_W(32)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .err_cnt_i (err_cnt_q),
    .ctrl_o    (ctrl),
    .rdata_o   (reg_rdata_o)
  );

  link_bist_ref_gen #(.WORD_W(WORD_W), .LFSR_W(LFSR_W), .TAP(TAP)) u_ref (
    .hist_i (hist_q),
    .exp_o  (exp_word),
    .next_o (hist_nxt)
  );

  assign run_en   = ctrl.pin_cfg ? bist_en_pin_i : ctrl.en;
  assign src_sel  = ctrl.pin_cfg ? clk_src_pin_i : ctrl.clk_src;
  assign word_err = synced_q & (~rx_lock_i | (|(rx_word_i ^ exp_word)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      synced_q   <= 1'b0;
      err_seen_q <= 1'b0;
      pulse_q    <= 1'b0;
      verdict_q  <= 1'b0;
      err_cnt_q  <= '0;
      hist_q     <= '0;
      src_q      <= 2'b00;
    end else if (!run_q) begin
      pulse_q <= 1'b0;
      if (run_en) begin
        run_q      <= 1'b1;
        synced_q   <= 1'b0;
        err_seen_q <= 1'b0;
        err_cnt_q  <= '0;
        src_q      <= src_sel;
      end
    end else if (!run_en) begin
      run_q     <= 1'b0;
      synced_q  <= 1'b0;
      pulse_q   <= 1'b0;
      verdict_q <= synced_q & ~err_seen_q;
    end else if (!synced_q) begin
      pulse_q <= 1'b0;
      if (rx_lock_i) begin
        synced_q <= 1'b1;
        hist_q   <= rx_word_i[WORD_W-1 -: LFSR_W];
      end
    end else begin
      hist_q  <= hist_nxt;
      pulse_q <= word_err;
      if (word_err) begin
        err_seen_q <= 1'b1;
        if (err_cnt_q != CNT_MAX) err_cnt_q <= err_cnt_q + 1'b1;
      end
    end
  end

  // test output follows the selected mode only during a seeded run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q <= 1'b0;
    end else if (run_q && run_en && synced_q) begin
      case (ctrl.out_mode)
        OUT_QUIET: tog_q <= 1'b0;
        OUT_ALT:   tog_q <= ~tog_q;
        default:   tog_q <= rx_word_i[0];
      endcase
    end else begin
      tog_q <= 1'b0;
    end
  end

  // error pulse occupies the high half of the cycle after the bad word
  assign pass_o        = run_q ? (synced_q & ~(pulse_q & clk_i)) : verdict_q;
  assign rem_clk_src_o = src_q;
  assign test_out_o    = tog_q;

  a_r3_no_pulse_unseeded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !synced_q |=> !pulse_q);
  a_r6_lock_loss_is_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && run_en && synced_q && !rx_lock_i) |=> (pulse_q && err_seen_q));
  a_r7_verdict_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !run_en) |=> $stable(verdict_q));
  a_r8_cnt_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && run_en) |=> (err_cnt_q >= $past(err_cnt_q)));
  a_r9_src_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && run_en) |=> $stable(rem_clk_src_o));
endmodule

// File: tb/link_bist_checker_bench.sv
`timescale 1ns/1ps
module link_bist_checker_bench;
  localparam int W = 35;
  localparam int NC = 6;
  // {words, err_word_a, err_word_b, lock_drop_word}; 0 = none, words numbered from 1
  localparam logic [31:0] CASES [NC] = '{
    {8'd12, 8'd0,  8'd0, 8'd0},
    {8'd12, 8'd4,  8'd0, 8'd0},
    {8'd16, 8'd3,  8'd9, 8'd9},
    {8'd10, 8'd10, 8'd0, 8'd0},
    {8'd14, 8'd1,  8'd2, 8'd6},
    {8'd9,  8'd0,  8'd0, 8'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  word = '0;
  logic          lock = 1'b0;
  logic          pin_en = 1'b0;
  logic [1:0]    pin_src = 2'b00;
  logic          wr = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [7:0]    wdata = '0;
  logic [31:0]   rdata;
  logic          pass;
  logic [1:0]    rem_src;
  logic          tout;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [30:0] sr;

  always #2 clk = ~clk;

  link_bist_checker u_link_bist_checker (
    .clk_i(clk), .rst_ni(rst_n), .rx_word_i(word), .rx_lock_i(lock),
    .bist_en_pin_i(pin_en), .clk_src_pin_i(pin_src), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pass_o(pass), .rem_clk_src_o(rem_src), .test_out_o(tout)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hi();  @(posedge clk); #0.5; endtask
  task automatic lo();  @(negedge clk); #0.5; endtask

  // serial model of s[n] = s[n-31] ^ s[n-28], bit 0 first
  task automatic next_word(output logic [W-1:0] w);
    for (int i = 0; i < W; i++) begin
      logic b;
      b = sr[30] ^ sr[27];
      w[i] = b;
      sr = {sr[29:0], b};
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic reg_wr(input logic [7:0] d);
    wr = 1'b1; addr = 2'd0; wdata = d;
    hi(); lo(); wr = 1'b0;
  endtask

  // enters in low phase with enable already driven; seeds and returns in low phase
  task automatic seed_run(input logic [30:0] seed, input logic [1:0] exp_src, input string tag);
    logic [31:0] d;
    logic [W-1:0] w;
    lock = 1'b0; word = '0;
    hi(); lo();
    chk(pass == 1'b0, {"R3 unseeded ", tag}, pass, 0);
    rd(2'd1, d);
    chk(d == 0, {"R8 cleared at start ", tag}, d, 0);
    chk(rem_src == exp_src, {"R9 src capture ", tag}, rem_src, exp_src);
    sr = seed;
    next_word(w);
    word = w; lock = 1'b1;
    hi();
    chk(pass == 1'b1, {"R3 pass after seed ", tag}, pass, 1);
    lo();
  endtask

  task automatic run_case(input int idx);
    logic [7:0] len, ea, eb, ld;
    logic [W-1:0] w;
    logic [31:0] d;
    int c;
    bit bad;
    {len, ea, eb, ld} = CASES[idx];
    c = (ea != 0) + (eb != 0 && eb != ea) + (ld != 0 && ld != ea && ld != eb);
    pin_src = 2'(idx);
    pin_en = 1'b1;
    seed_run(31'h2A5A0001 ^ (31'(idx) << 8), 2'(idx), "table");
    for (int k = 1; k <= int'(len); k++) begin
      next_word(w);
      bad = (k == int'(ea)) || (k == int'(eb));
      word = bad ? (w ^ (35'd1 << ((k * 7) % W))) : w;
      lock = (k != int'(ld));
      bad = bad || (k == int'(ld));
      hi();
      chk(pass == !bad, bad ? "R5 R6 error pulse high phase" : "R4 match keeps pass high", pass, !bad);
      chk(tout == 1'b0, "R10 quiet mode", tout, 0);
      lo();
      chk(pass == 1'b1, "R5 pass back high in low phase", pass, 1);
    end
    pin_en = 1'b0;
    next_word(w); word = w ^ 35'h7;
    hi();
    chk(pass == (c == 0), "R7 verdict at stop", pass, (c == 0));
    lo();
    rd(2'd1, d);
    chk(d == 32'(c), "R8 error count", d, c);
    for (int k = 0; k < 3; k++) begin
      lock = ~lock; word = ~word;
      hi(); lo();
      chk(pass == (c == 0), "R7 verdict held", pass, (c == 0));
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [W-1:0] w;
    logic exp_t;
    repeat (3) @(posedge clk);
    lo();
    chk(pass == 1'b0, "R1 reset pass", pass, 0);
    chk(tout == 1'b0, "R1 reset test_out", tout, 0);
    chk(rem_src == 2'b00, "R1 reset src", rem_src, 0);
    rst_n = 1'b1;
    rd(2'd0, d); chk(d == 32'h08, "R1 reset ctrl", d, 32'h08);
    rd(2'd1, d); chk(d == 0, "R1 reset count", d, 0);

    for (int i = 0; i < NC; i++) run_case(i);

    // run that never locks: verdict must fall to 0
    pin_src = 2'b11; pin_en = 1'b1; lock = 1'b0;
    hi(); lo();
    chk(rem_src == 2'b11, "R9 src at run start", rem_src, 3);
    repeat (3) begin hi(); lo(); end
    chk(pass == 1'b0, "R3 no lock keeps pass low", pass, 0);
    pin_en = 1'b0;
    hi(); lo();
    chk(pass == 1'b0, "R7 unseeded run fails", pass, 0);

    // register enable mode: pin must be ignored
    reg_wr(8'h04);
    pin_src = 2'b01; pin_en = 1'b1; lock = 1'b1; word = 35'h1234;
    repeat (4) begin hi(); lo(); end
    chk(pass == 1'b0, "R2 pin ignored pass", pass, 0);
    chk(rem_src == 2'b11, "R2 pin ignored src", rem_src, 3);
    pin_en = 1'b0;
    reg_wr(8'h05);
    rd(2'd0, d); chk(d == 32'h05, "R11 ctrl readback", d, 32'h05);
    seed_run(31'h0F0F1234, 2'b10, "reg mode");
    for (int k = 0; k < 3; k++) begin
      next_word(w); word = w;
      hi(); chk(pass == 1'b1, "R2 register run checks", pass, 1); lo();
    end
    next_word(w); word = w;
    reg_wr(8'h04);
    next_word(w); word = w;
    hi(); lo();
    chk(pass == 1'b1, "R2 R7 register stop verdict", pass, 1);

    // alternating output mode
    reg_wr(8'h48);
    pin_en = 1'b1;
    seed_run(31'h11223344, 2'b01, "alt mode");
    chk(tout == 1'b0, "R10 alt starts low", tout, 0);
    exp_t = 1'b0;
    for (int k = 0; k < 4; k++) begin
      next_word(w); word = w; exp_t = ~exp_t;
      hi(); chk(tout == exp_t, "R10 alternating", tout, exp_t); lo();
    end
    pin_en = 1'b0; hi(); lo();
    chk(tout == 1'b0, "R10 idle output low", tout, 0);

    // data-following output mode
    reg_wr(8'h88);
    pin_en = 1'b1;
    seed_run(31'h7654321, 2'b01, "data mode");
    for (int k = 0; k < 5; k++) begin
      next_word(w); word = w;
      hi(); chk(tout == w[0], "R10 follows data", tout, w[0]); lo();
    end
    pin_en = 1'b0; hi(); lo();
    chk(pass == 1'b1, "R7 data mode verdict", pass, 1);

    reg_wr(8'hFF);
    rd(2'd0, d); chk(d == 32'hCF, "R11 bits 5:4 read zero", d, 32'hCF);
    hi(); lo();
    rd(2'd0, d); chk(d == 32'hCF, "R11 held without write", d, 32'hCF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule